// File: doc/BRIEF.md
# I2C Master Clock Generator with Line Synchronization

This block produces the serial clock for an I2C master from a faster source clock. A 16-bit divisor N sets the nominal rate to f_clk / N, and each period is split into a low phase and a high phase. The block drives the shared clock line only through an open-drain pull-low request. It watches the line level that comes back, so other masters and clock-stretching slaves can lengthen the low phase or cut the high phase short, as wired-AND signalling requires.

A byte engine built on top of this block uses two one-cycle strobes. The fall strobe marks the cycle in which a low phase begins, so SDA can be updated. The rise strobe marks the cycle in which the high phase starts counting on the bus, so SDA can be sampled. With the enable low the block sits idle and never pulls the line. A mode input chooses the smallest divisor allowed: 4 with a single master, 8 with several masters.

Top module: `scl_clk_gen`

## Requirements
- R1: During reset and in the first cycle after it, `scl_pull_o`, `rise_o` and `fall_o` are all 0.
- R2: While `en_i` is 0 the block never pulls the line and emits no strobes, whatever the line does. Clearing `en_i` releases the pull request in the next cycle.
- R3: For an even effective divisor N, `fall_o` is followed by `rise_o` after N/2 + 3 cycles (the pull request lasts N/2 cycles, then the two-stage synchronizer and the phase register add 3), and `rise_o` is followed by the next `fall_o` after N/2 cycles.
- R4: For an odd effective divisor N, the extra cycle goes to the low phase. The pull request lasts (N+1)/2 cycles, so fall-to-rise is (N+1)/2 + 3. The high phase lasts (N-1)/2 cycles.
- R5: With `multi_i` = 0, a programmed divisor below 4 behaves as 4.
- R6: With `multi_i` = 1, a programmed divisor below 8 (0 included) behaves as 8.
- R7: After its low count ends, the block releases the line. Its high count starts only when the synchronized line reads high. If another device holds the line low for X cycles from the start of the low phase, fall-to-rise is max(low length, X) + 3.
- R8: If the line goes low Y cycles after `rise_o` while the high phase is still counting, `fall_o` is raised Y + 3 cycles after `rise_o`. A full low phase then follows.
- R9: `fall_o` and `rise_o` each last one cycle and never occur together. The pull request goes high only in the cycle of `fall_o`, and it is low whenever `rise_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Master mode; 0 keeps the generator idle |
| multi_i | input | 1 | 1 selects the multi-master divisor floor (8); 0 selects the single-master floor (4) |
| div_i | input | 16 | Programmed divisor, unsigned |
| scl_bus_i | input | 1 | Raw level of the shared clock line |
| scl_pull_o | output | 1 | Open-drain request: 1 pulls the line low |
| rise_o | output | 1 | One-cycle strobe: the high phase starts on the bus |
| fall_o | output | 1 | One-cycle strobe: a low phase starts |

## Verification
The checker relies on `scl_bus_i` being the wired-AND of this block's own pull request and any external pull, so the line never reads high while `scl_pull_o` is set. It also relies on `div_i` and `multi_i` staying constant while `en_i` is high. The bench models the line as the inverse of the OR of `scl_pull_o` and a bench-driven external pull. It changes the divisor and mode only while the generator is disabled. External stretches are applied only from a fall strobe, and high-phase interruptions only from a rise strobe, with widths shorter than a period, so that each measured period can be predicted.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    // Width of the divisor and of the phase counter
    localparam int unsigned DIV_W = 16;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [DIV_W-1:0]   cnt;
        logic               pull;
        logic               rise;
        logic               fall;
    } gen_state_t;

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb chain_d[g] = d_i;
        end else begin : g_next
            always_comb chain_d[g] = chain_q[g-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/scl_div_split.sv
module scl_div_split #(
    parameter int unsigned W     = 16,
    parameter int unsigned MIN_S = 4,
    parameter int unsigned MIN_M = 8
) (
    input  logic [W-1:0] div_i,
    input  logic         multi_i,
    output logic [W-1:0] low_len_o,
    output logic [W-1:0] high_len_o
);

    localparam logic [W-1:0] FLOOR_S = W'(MIN_S);
    localparam logic [W-1:0] FLOOR_M = W'(MIN_M);

    logic [W-1:0] floor_v;
    logic [W-1:0] eff_v;

    always_comb begin
        floor_v    = multi_i ? FLOOR_M : FLOOR_S;
        eff_v      = (div_i < floor_v) ? floor_v : div_i;
        // high gets the floor half; any odd remainder lands in low
        high_len_o = eff_v >> 1;
        low_len_o  = eff_v - (eff_v >> 1);
    end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             bus_hi_i,
    input  logic [DIV_W-1:0] low_len_i,
    input  logic [DIV_W-1:0] high_len_i,
    output logic             pull_o,
    output logic             rise_o,
    output logic             fall_o
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    gen_state_t s_d;
    gen_state_t s_q;

    always_comb begin
        s_d      = s_q;
        s_d.rise = 1'b0;
        s_d.fall = 1'b0;
        if (!en_i) begin
            s_d.phase = PH_IDLE;
            s_d.cnt   = '0;
            s_d.pull  = 1'b0;
        end else begin
            unique case (s_q.phase)
                PH_IDLE: begin
                    s_d.phase = PH_LOW;
                    s_d.cnt   = low_len_i - ONE;
                    s_d.pull  = 1'b1;
                    s_d.fall  = 1'b1;
                end
                PH_LOW: begin
                    if (s_q.cnt == '0) begin
                        s_d.phase = PH_WAIT;
                        s_d.pull  = 1'b0;
                    end else begin
                        s_d.cnt = s_q.cnt - ONE;
                    end
                end
                PH_WAIT: begin
                    if (bus_hi_i) begin
                        s_d.phase = PH_HIGH;
                        s_d.cnt   = high_len_i - ONE;
                        s_d.rise  = 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (!bus_hi_i || s_q.cnt == '0) begin
                        s_d.phase = PH_LOW;
                        s_d.cnt   = low_len_i - ONE;
                        s_d.pull  = 1'b1;
                        s_d.fall  = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt - ONE;
                    end
                end
                default: begin
                    s_d.phase = PH_IDLE;
                    s_d.cnt   = '0;
                    s_d.pull  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pull_o = s_q.pull;
    assign rise_o = s_q.rise;
    assign fall_o = s_q.fall;

endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen
    import scl_gen_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_DIV_S   = 4,
    parameter int unsigned MIN_DIV_M   = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             multi_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             scl_bus_i,
    output logic             scl_pull_o,
    output logic             rise_o,
    output logic             fall_o
);

    logic             bus_hi;
    logic [DIV_W-1:0] low_len;
    logic [DIV_W-1:0] high_len;

    scl_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (scl_bus_i),
        .q_o    (bus_hi)
    );

    scl_div_split #(
        .W     (DIV_W),
        .MIN_S (MIN_DIV_S),
        .MIN_M (MIN_DIV_M)
    ) i_split (
        .div_i      (div_i),
        .multi_i    (multi_i),
        .low_len_o  (low_len),
        .high_len_o (high_len)
    );

    scl_phase_fsm i_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (en_i),
        .bus_hi_i   (bus_hi),
        .low_len_i  (low_len),
        .high_len_i (high_len),
        .pull_o     (scl_pull_o),
        .rise_o     (rise_o),
        .fall_o     (fall_o)
    );

endmodule

// File: rtl/scl_clk_gen_chk.sv
module scl_clk_gen_chk
    import scl_gen_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en_i,
    input logic             multi_i,
    input logic [DIV_W-1:0] div_i,
    input logic             scl_bus_i,
    input logic             scl_pull_o,
    input logic             rise_o,
    input logic             fall_o
);

    // R2
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!scl_pull_o && !rise_o && !fall_o));

    // R9
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rise_o && fall_o));

    // R9
    pull_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(scl_pull_o) |-> fall_o);

    // R9
    fall_pull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |-> scl_pull_o);

    // R9
    rise_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |-> !scl_pull_o);

    // R7
    rise_after_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |-> $past(scl_bus_i, 3));

    // R1
    always_comb begin
        if (!rst_ni) begin
            reset_quiet_chk: assert (!rise_o && !fall_o && !scl_pull_o);
        end
    end

endmodule

bind scl_clk_gen scl_clk_gen_chk i_chk (.*);

// File: tb/test_scl_clk_gen.sv
module test_scl_clk_gen;

    typedef struct {
        int    lo;
        int    hi;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        multi = 1'b0;
    logic [15:0] div = 16'd10;
    logic        ext_low = 1'b0;
    logic        scl_bus;
    logic        scl_pull;
    logic        rise;
    logic        fall;

    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   stretch_x = 0;
    int   intr_y = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    assign scl_bus = ~(scl_pull | ext_low);

    scl_clk_gen i_scl_clk_gen (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .en_i       (en),
        .multi_i    (multi),
        .div_i      (div),
        .scl_bus_i  (scl_bus),
        .scl_pull_o (scl_pull),
        .rise_o     (rise),
        .fall_o     (fall)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: measure fall->rise and rise->fall, compare against queue
    int  t_fall = 0;
    int  t_rise = 0;
    int  lo_meas = 0;
    bit  have_fall = 0;
    bit  have_rise = 0;
    always @(negedge clk) begin
        cyc++;
        if (rise && fall) check(0, "R9", "rise and fall together", 1, 0);
        if (!en) begin
            have_fall = 0;
            have_rise = 0;
        end else begin
            if (fall) begin
                if (!scl_pull) check(0, "R9", "pull at fall strobe", 0, 1);
                if (have_rise && exp_q.size() != 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(lo_meas == e.lo, e.req, "fall-to-rise cycles", lo_meas, e.lo);
                    check(cyc - t_rise == e.hi, e.req, "rise-to-fall cycles",
                          cyc - t_rise, e.hi);
                end
                have_rise = 0;
                t_fall    = cyc;
                have_fall = 1;
            end
            if (rise && have_fall) begin
                lo_meas   = cyc - t_fall;
                t_rise    = cyc;
                have_rise = 1;
                have_fall = 0;
            end
        end
    end

    // external device: stretch from fall, or interrupt high after rise
    always @(negedge clk) begin
        if (en && fall && stretch_x > 0) begin
            ext_low = 1'b1;
            repeat (stretch_x) @(negedge clk);
            ext_low = 1'b0;
        end else if (en && rise && intr_y > 0) begin
            repeat (intr_y) @(negedge clk);
            ext_low = 1'b1;
            repeat (2) @(negedge clk);
            ext_low = 1'b0;
        end
    end

    function automatic int eff_div(input int d, input bit m);
        int fl;
        fl = m ? 8 : 4;
        return (d < fl) ? fl : d;
    endfunction

    // driver: configure, push expected periods, wait for the monitor
    task automatic run_cfg(input int d, input bit m, input int sx, input int iy,
                           input int n, input string req);
        int e;
        int lo;
        int hi;
        @(negedge clk);
        div       = 16'(d);
        multi     = m;
        stretch_x = sx;
        intr_y    = iy;
        e  = eff_div(d, m);
        lo = e - e / 2;
        hi = e / 2;
        for (int i = 0; i < n; i++) begin
            exp_t x;
            x.lo  = ((sx > lo) ? sx : lo) + 3;
            x.hi  = (iy > 0) ? iy + 3 : hi;
            x.req = req;
            exp_q.push_back(x);
        end
        en = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        en = 1'b0;
        stretch_x = 0;
        intr_y    = 0;
        repeat (6) @(negedge clk);
    endtask

    task automatic run_all();
        int bad;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(!scl_pull && !rise && !fall, "R1", "outputs in reset",
              int'({scl_pull, rise, fall}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scl_pull && !rise && !fall, "R1", "outputs after reset",
              int'({scl_pull, rise, fall}), 0);

        // R2 idle: external pulses, no pull or strobe
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            ext_low = (i % 7) < 3;
            @(negedge clk);
            if (scl_pull || rise || fall) bad++;
        end
        ext_low = 1'b0;
        check(bad == 0, "R2", "activity while disabled", bad, 0);

        run_cfg(10, 1'b0, 0, 0, 3, "R3");
        run_cfg(40, 1'b0, 0, 0, 2, "R3");
        run_cfg(9, 1'b0, 0, 0, 3, "R4");
        run_cfg(1001, 1'b0, 0, 0, 2, "R4");
        run_cfg(2, 1'b0, 0, 0, 3, "R5");
        run_cfg(0, 1'b0, 0, 0, 2, "R5");
        run_cfg(5, 1'b1, 0, 0, 3, "R6");
        run_cfg(0, 1'b1, 0, 0, 2, "R6");
        run_cfg(41, 1'b0, 30, 0, 3, "R7");
        run_cfg(41, 1'b0, 10, 0, 2, "R7");
        run_cfg(40, 1'b0, 0, 5, 3, "R8");
        run_cfg(41, 1'b1, 0, 9, 2, "R8");

        // R2 disabling mid-low releases the line next cycle
        div = 16'd40;
        multi = 1'b0;
        en = 1'b1;
        repeat (5) @(negedge clk);
        check(scl_pull == 1'b1, "R2", "pull while low phase runs", int'(scl_pull), 1);
        en = 1'b0;
        @(negedge clk);
        check(scl_pull == 1'b0, "R2", "pull after disable", int'(scl_pull), 0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            end
        join_any
        disable fork;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule